// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by walking translation tables held in memory. A walk starts from a root table pointer and a context number, reads one descriptor from the context table, and then descends through up to three levels of tables. It stops at the first level that holds a page entry, so a single walk maps a 16 MB, 256 KB or 4 KB page. The walker talks to memory through a 32-bit word port with a ready handshake. When the page entry lacks its referenced mark, or a store meets a page entry without its modified mark, the walker writes the updated entry back to the address it was read from.

With translation switched off no memory access takes place. Instruction fetches in boot mode go to a fixed window at the top of the physical space, and every other access passes straight through. The result is either a physical address with the final entry's access field and modified mark, or a fault code that gives the level and the kind of the bad entry. Permission checks and caching of translations happen elsewhere.

Top module: `xlat_walker`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are low.
- R2: With translation on, the first memory read of a walk is at (root_ptr_i << 4) + (ctx_i << 2), using the values present when the request is accepted.
- R3: Entry type is bits [1:0]: 0 invalid, 1 table descriptor, 2 page entry, 3 reserved. A descriptor leads to a read at ((entry with bits [1:0] cleared) << 4) + 4 * index, where the index is VA[31:24] after the context level, VA[23:18] after level 1 and VA[17:12] after level 2.
- R4: A bad entry gives fault_o high and fault_code_o = (level << 8) | 0x04 for an invalid entry or (level << 8) | 0x10 for a reserved one. The context level is level 0, where a page entry counts as reserved. At level 3 a table descriptor counts as reserved.
- R5: A page entry at level 1 gives pa_o = (entry[31:8] << 12) + VA[23:0].
- R6: A page entry at level 2 gives pa_o = (entry[31:8] << 12) + VA[17:0].
- R7: A page entry at level 3 gives pa_o = (entry[31:8] << 12) + VA[11:0].
- R8: A page entry has its referenced mark in bit 5 and its modified mark in bit 6. The access kind req_kind_i is 0 load, 1 store, 2 fetch; bit 0 marks a write. If bit 5 is clear, or the access writes and bit 6 is clear, the walker writes back one word to the same address with bit 5 set, and with bit 6 set too when the access writes. Otherwise it writes nothing.
- R9: A walked result gives acc_o = entry[4:2] and mod_o = bit 6 of the entry after the update, with rights_o = 0.
- R10: With mmu_en_i low and boot_i high, a fetch yields pa_o = 0xF_F000_0000 | VA[17:0] and rights_o = 3'b101 ({read, write, execute}). No memory access is made.
- R11: With mmu_en_i low, any other access yields pa_o = VA zero-extended and rights_o = 3'b111. No memory access is made, and boot_i has no effect on loads and stores.
- R12: A request is accepted only while busy_o is low. busy_o stays high until done_o, done_o lasts one cycle, and requests made while busy are ignored.
- R13: A memory request keeps its address, write enable and data stable until mem_ready_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| root_ptr_i | input | 32 | Context table pointer, shifted left 4 to make the byte address |
| ctx_i | input | CTX_W | Context number |
| mmu_en_i | input | 1 | Translation enable |
| boot_i | input | 1 | Boot mode: fetches go to the fixed window while translation is off |
| req_valid_i | input | 1 | Request strobe, taken while idle |
| req_va_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | 0 load, 1 store, 2 fetch |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 1 | Result is a fault |
| fault_code_o | output | 10 | Level in [9:8], kind in [7:0] |
| pa_o | output | 36 | Physical address |
| acc_o | output | 3 | Access field of the final entry |
| mod_o | output | 1 | Modified mark of the final entry |
| rights_o | output | 3 | {read, write, execute} for untranslated results, 0 when walked |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 36 | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Access complete |

## Verification
Translation is tried with walks that end at each of the three levels, which shows that the offset width and the table index are picked per level, and with faults at every level, which shows the level count in the code. Loads, stores and fetches meet page entries whose referenced and modified marks are clear, half set and fully set. This separates the write-back cases by the write data and the number of writes. Memory latency changes from read to read to test the handshake. Requests with translation off, with and without boot mode and for each access kind, show the address window and the rights and confirm that memory stays idle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 36;
  localparam int ENT_W = 32;
  localparam int FC_W  = 10;
  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTX, ST_L1, ST_L2, ST_L3, ST_WB, ST_DONE
  } walk_st_e;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0, ET_TABLE = 2'd1, ET_PAGE = 2'd2, ET_RESERVED = 2'd3
  } etype_e;

  function automatic logic [PA_W-1:0] root_entry_addr(logic [31:0] root, logic [31:0] ctx);
    return {root, 4'b0000} + {2'b00, ctx, 2'b00};
  endfunction

  function automatic logic [7:0] table_index(logic [VA_W-1:0] va, logic [1:0] lvl);
    case (lvl)
      2'd0:    return va[31:24];
      2'd1:    return {2'b00, va[23:18]};
      default: return {2'b00, va[17:12]};
    endcase
  endfunction

  function automatic logic [PA_W-1:0] next_table_addr(logic [ENT_W-1:0] ent, logic [7:0] idx);
    return {ent[31:2], 2'b00, 4'b0000} + {26'd0, idx, 2'b00};
  endfunction

  function automatic logic [PA_W-1:0] leaf_addr(logic [ENT_W-1:0] ent, logic [VA_W-1:0] va,
                                                 logic [1:0] lvl);
    logic [PA_W-1:0] off;
    case (lvl)
      2'd1:    off = {12'd0, va[23:0]};
      2'd2:    off = {18'd0, va[17:0]};
      default: off = {24'd0, va[11:0]};
    endcase
    return {ent[31:8], 12'd0} + off;
  endfunction

  function automatic logic [FC_W-1:0] fault_code(logic [1:0] lvl, logic rsv);
    return {lvl, (rsv ? 8'h10 : 8'h04)};
  endfunction

  function automatic logic needs_wb(logic [ENT_W-1:0] ent, logic wr);
    return !ent[REF_BIT] || (wr && !ent[MOD_BIT]);
  endfunction

  function automatic logic [ENT_W-1:0] marked_entry(logic [ENT_W-1:0] ent, logic wr);
    logic [ENT_W-1:0] e;
    e = ent;
    e[REF_BIT] = 1'b1;
    if (wr) e[MOD_BIT] = 1'b1;
    return e;
  endfunction
endpackage

// File: rtl/xlat_entry_eval.sv
module xlat_entry_eval
  import xlat_pkg::*;
(
  input  logic [ENT_W-1:0] ent_i,
  input  logic [1:0]       lvl_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic             wr_i,
  output logic             descend_o,
  output logic             leaf_o,
  output logic             fault_o,
  output logic [FC_W-1:0]  fcode_o,
  output logic [PA_W-1:0]  next_addr_o,
  output logic [PA_W-1:0]  leaf_pa_o,
  output logic             wb_need_o,
  output logic [ENT_W-1:0] wb_data_o
);
  etype_e et;
  assign et = etype_e'(ent_i[1:0]);

  always_comb begin
    descend_o = 1'b0;
    leaf_o    = 1'b0;
    fault_o   = 1'b0;
    fcode_o   = '0;
    case (et)
      ET_TABLE: begin
        if (lvl_i == 2'd3) begin
          fault_o = 1'b1;
          fcode_o = fault_code(lvl_i, 1'b1);
        end else begin
          descend_o = 1'b1;
        end
      end
      ET_PAGE: begin
        if (lvl_i == 2'd0) begin
          fault_o = 1'b1;
          fcode_o = fault_code(lvl_i, 1'b1);
        end else begin
          leaf_o = 1'b1;
        end
      end
      ET_INVALID: begin
        fault_o = 1'b1;
        fcode_o = fault_code(lvl_i, 1'b0);
      end
      default: begin
        fault_o = 1'b1;
        fcode_o = fault_code(lvl_i, 1'b1);
      end
    endcase
  end

  assign next_addr_o = next_table_addr(ent_i, table_index(va_i, lvl_i));
  assign leaf_pa_o   = leaf_addr(ent_i, va_i, lvl_i);
  assign wb_need_o   = needs_wb(ent_i, wr_i);
  assign wb_data_o   = marked_entry(ent_i, wr_i);
endmodule

// File: rtl/xlat_bypass.sv
module xlat_bypass
  import xlat_pkg::*;
(
  input  logic [VA_W-1:0] va_i,
  input  logic [1:0]      kind_i,
  input  logic            boot_i,
  output logic [PA_W-1:0] pa_o,
  output logic [2:0]      rights_o
);
  logic prom_hit;
  assign prom_hit = boot_i && (kind_i == 2'd2);
  assign pa_o     = prom_hit ? (36'hF_F000_0000 | {18'd0, va_i[17:0]}) : {4'd0, va_i};
  assign rights_o = prom_hit ? 3'b101 : 3'b111;
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      root_ptr_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic             mmu_en_i,
  input  logic             boot_i,
  input  logic             req_valid_i,
  input  logic [31:0]      req_va_i,
  input  logic [1:0]       req_kind_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [9:0]       fault_code_o,
  output logic [35:0]      pa_o,
  output logic [2:0]       acc_o,
  output logic             mod_o,
  output logic [2:0]       rights_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [35:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic [31:0]      mem_rdata_i,
  input  logic             mem_ready_i
);
  localparam int CTX_PAD = 32 - CTX_W;

  walk_st_e         st_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [PA_W-1:0]  ptr_q;
  logic [ENT_W-1:0] wb_q;
  logic [PA_W-1:0]  pa_q;
  logic [2:0]       acc_q, rights_q;
  logic             mod_q, fault_q;
  logic [FC_W-1:0]  code_q;

  // named events
  logic accept, rd_beat, wb_beat;
  logic [1:0] lvl;
  walk_st_e   deeper;

  always_comb begin
    lvl    = 2'd0;
    deeper = ST_L1;
    case (st_q)
      ST_L1:   begin lvl = 2'd1; deeper = ST_L2; end
      ST_L2:   begin lvl = 2'd2; deeper = ST_L3; end
      ST_L3:   begin lvl = 2'd3; deeper = ST_L3; end
      default: begin lvl = 2'd0; deeper = ST_L1; end
    endcase
  end

  assign accept  = (st_q == ST_IDLE) && req_valid_i;
  assign rd_beat = mem_req_o && !mem_we_o && mem_ready_i;
  assign wb_beat = mem_we_o && mem_ready_i;

  logic             ev_descend, ev_leaf, ev_fault, ev_wb_need;
  logic [FC_W-1:0]  ev_code;
  logic [PA_W-1:0]  ev_next, ev_pa;
  logic [ENT_W-1:0] ev_wb_data;

  xlat_entry_eval eval_i (
    .ent_i(mem_rdata_i), .lvl_i(lvl), .va_i(va_q), .wr_i(wr_q),
    .descend_o(ev_descend), .leaf_o(ev_leaf), .fault_o(ev_fault), .fcode_o(ev_code),
    .next_addr_o(ev_next), .leaf_pa_o(ev_pa), .wb_need_o(ev_wb_need), .wb_data_o(ev_wb_data)
  );

  logic [PA_W-1:0] byp_pa;
  logic [2:0]      byp_rights;

  xlat_bypass byp_i (
    .va_i(req_va_i), .kind_i(req_kind_i), .boot_i(boot_i),
    .pa_o(byp_pa), .rights_o(byp_rights)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      va_q     <= '0;
      wr_q     <= 1'b0;
      ptr_q    <= '0;
      wb_q     <= '0;
      pa_q     <= '0;
      acc_q    <= '0;
      rights_q <= '0;
      mod_q    <= 1'b0;
      fault_q  <= 1'b0;
      code_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          va_q    <= req_va_i;
          wr_q    <= req_kind_i[0];
          fault_q <= 1'b0;
          code_q  <= '0;
          acc_q   <= '0;
          mod_q   <= 1'b0;
          if (!mmu_en_i) begin
            pa_q     <= byp_pa;
            rights_q <= byp_rights;
            st_q     <= ST_DONE;
          end else begin
            ptr_q    <= root_entry_addr(root_ptr_i, {{CTX_PAD{1'b0}}, ctx_i});
            rights_q <= '0;
            st_q     <= ST_CTX;
          end
        end
        ST_CTX, ST_L1, ST_L2, ST_L3: if (rd_beat) begin
          if (ev_fault) begin
            fault_q <= 1'b1;
            code_q  <= ev_code;
            st_q    <= ST_DONE;
          end else if (ev_descend) begin
            ptr_q <= ev_next;
            st_q  <= deeper;
          end else if (ev_leaf) begin
            pa_q  <= ev_pa;
            acc_q <= mem_rdata_i[4:2];
            mod_q <= ev_wb_data[MOD_BIT];
            wb_q  <= ev_wb_data;
            st_q  <= ev_wb_need ? ST_WB : ST_DONE;
          end
        end
        ST_WB:   if (wb_beat) st_q <= ST_DONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_DONE);
  assign fault_o      = fault_q;
  assign fault_code_o = code_q;
  assign pa_o         = pa_q;
  assign acc_o        = acc_q;
  assign mod_o        = mod_q;
  assign rights_o     = rights_q;
  assign mem_req_o    = (st_q == ST_CTX) || (st_q == ST_L1) || (st_q == ST_L2) ||
                        (st_q == ST_L3) || (st_q == ST_WB);
  assign mem_we_o     = (st_q == ST_WB);
  assign mem_addr_o   = ptr_q;
  assign mem_wdata_o  = wb_q;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy_o,
  input logic        done_o,
  input logic        fault_o,
  input logic [9:0]  fault_code_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [35:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ready_i,
  input logic        rd_beat,
  input logic        accept
);
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R13
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o); // R12
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy_o); // R12
  AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_o) |-> mem_addr_o == $past(mem_addr_o)); // R8
  AST_WB_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_wdata_o[5]); // R8
  AST_FAULT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fault_o |-> (fault_code_o[7:0] == 8'h04) || (fault_code_o[7:0] == 8'h10)); // R4
  AST_BEAT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat |-> busy_o && !done_o); // R13
endmodule

bind xlat_walker xlat_walker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
  .fault_code_o(fault_code_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
  .rd_beat(rd_beat), .accept(accept)
);

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] root_ptr = 32'h0010_0000;
  logic [7:0]  ctx = 8'd5;
  logic        mmu_en = 1'b1, boot = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [1:0]  req_kind = '0;
  logic        busy, done, fault, mod_b, mem_req, mem_we;
  logic [9:0]  fcode;
  logic [35:0] pa, mem_addr;
  logic [2:0]  acc, rights;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  xlat_walker #(.CTX_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .root_ptr_i(root_ptr), .ctx_i(ctx), .mmu_en_i(mmu_en),
    .boot_i(boot), .req_valid_i(req_valid), .req_va_i(req_va), .req_kind_i(req_kind),
    .busy_o(busy), .done_o(done), .fault_o(fault), .fault_code_o(fcode), .pa_o(pa),
    .acc_o(acc), .mod_o(mod_b), .rights_o(rights), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready)
  );

  int checks = 0, errors = 0;
  int nreads = 0, nwrites = 0, wait_cnt = 0, ndone = 0;
  logic [35:0] first_raddr = '0, last_waddr = '0;
  logic [31:0] last_wdata = '0;
  logic        arm_first = 1'b0;
  logic [31:0] mem [logic [35:0]];

  localparam logic [35:0] L1B = 36'h0_0200_0000;
  localparam logic [35:0] L2B = 36'h0_0300_0000;
  localparam logic [35:0] L3B = 36'h0_0400_0000;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_tab(input logic [35:0] base);
    return {base[35:6], 2'b01};
  endfunction
  function automatic logic [31:0] mk_pte(input logic [35:0] ppa, input logic [2:0] a,
                                         input logic r, input logic m);
    return {ppa[35:12], 1'b0, m, r, a, 2'b10};
  endfunction

  // memory model: variable latency, acts at negedge
  always @(negedge clk) begin
    if (done) ndone++;
    if (mem_ready) begin
      mem_ready <= 1'b0;
      wait_cnt  = 0;
    end else if (mem_req) begin
      if (wait_cnt >= (nreads % 3)) begin
        mem_ready <= 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          nwrites++;
          last_waddr = mem_addr;
          last_wdata = mem_wdata;
        end else begin
          mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
          if (arm_first) begin first_raddr = mem_addr; arm_first = 1'b0; end
          nreads++;
        end
      end else begin
        wait_cnt++;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  int rd0, wr0;
  task automatic xlat(input logic [31:0] va, input logic [1:0] kind);
    int t;
    @(negedge clk);
    while (busy) @(negedge clk);
    rd0 = nreads; wr0 = nwrites; arm_first = 1'b1;
    req_valid = 1'b1; req_va = va; req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    check(done, "R12 done seen", {63'd0, done}, 64'd1);
  endtask

  task automatic t_reset();
    check(!busy && !done && !mem_req, "R1 reset outputs", {busy, done, mem_req}, 0);
  endtask

  task automatic t_l1_leaf();
    ctx = 8'd5;
    xlat(32'h1234_5678, 2'd0);
    check(first_raddr == 36'h0_0100_0014, "R2 first read", first_raddr, 36'h0_0100_0014);
    check(!fault && pa == 36'h3_4534_5678, "R5 16MB pa", pa, 36'h3_4534_5678);
    check(nreads - rd0 == 2, "R3 reads for level1 leaf", nreads - rd0, 2);
    check(nwrites == wr0, "R8 no writeback when marks set", nwrites - wr0, 0);
    check(acc == 3'd3 && mod_b && rights == 3'b000, "R9 acc/mod/rights", {acc, mod_b, rights}, {3'd3, 1'b1, 3'd0});
  endtask

  task automatic t_l2_leaf();
    logic [35:0] ea;
    ea = L2B + {28'd0, 6'h2B, 2'b00};
    xlat(32'h34AC_0123, 2'd0);
    check(pa == 36'h0_8004_0000 + 36'h00123, "R6 256KB pa", pa, 36'h0_8004_0123);
    check(nreads - rd0 == 3, "R3 reads for level2 leaf", nreads - rd0, 3);
    check(nwrites - wr0 == 1 && last_waddr == ea, "R8 load writeback address", last_waddr, ea);
    check(last_wdata == (mk_pte(36'h0_8004_0000, 3'd5, 1'b0, 1'b0) | 32'h20), "R8 load sets referenced only",
          last_wdata, mk_pte(36'h0_8004_0000, 3'd5, 1'b0, 1'b0) | 32'h20);
    check(acc == 3'd5 && !mod_b, "R9 mod clear after load", {acc, mod_b}, {3'd5, 1'b0});
    xlat(32'h34AF_FFFC, 2'd1);
    check(pa == 36'h0_8007_FFFC, "R6 256KB top offset", pa, 36'h0_8007_FFFC);
    check(nwrites - wr0 == 1 && last_wdata == (mk_pte(36'h0_8004_0000, 3'd5, 1'b0, 1'b0) | 32'h60),
          "R8 store sets modified", last_wdata, mk_pte(36'h0_8004_0000, 3'd5, 1'b0, 1'b0) | 32'h60);
    check(mod_b, "R9 mod set after store", {63'd0, mod_b}, 1);
    xlat(32'h34AC_0004, 2'd1);
    check(nwrites == wr0 && mod_b, "R8 store on modified page writes nothing", nwrites - wr0, 0);
  endtask

  task automatic t_l3_leaf();
    xlat(32'h34C5_6789, 2'd2);
    check(!fault && pa == 36'h9_ABCD_E789, "R7 4KB pa", pa, 36'h9_ABCD_E789);
    check(nreads - rd0 == 4, "R3 reads for level3 leaf", nreads - rd0, 4);
    check(acc == 3'd2 && nwrites == wr0, "R9 level3 acc", acc, 3'd2);
  endtask

  task automatic t_faults();
    xlat(32'h0000_1000, 2'd0);
    check(fault && fcode == 10'h104, "R4 L1 invalid", fcode, 10'h104);
    xlat(32'h0100_0000, 2'd0);
    check(fault && fcode == 10'h110, "R4 L1 reserved", fcode, 10'h110);
    xlat(32'h3414_0000, 2'd0);
    check(fault && fcode == 10'h204, "R4 L2 invalid", fcode, 10'h204);
    xlat(32'h3418_0000, 2'd0);
    check(fault && fcode == 10'h210, "R4 L2 reserved", fcode, 10'h210);
    xlat(32'h34C5_7000, 2'd0);
    check(fault && fcode == 10'h310, "R4 L3 descriptor as reserved", fcode, 10'h310);
    xlat(32'h34C5_8000, 2'd0);
    check(fault && fcode == 10'h304, "R4 L3 invalid", fcode, 10'h304);
    ctx = 8'd6;
    xlat(32'h1234_5678, 2'd0);
    check(first_raddr == 36'h0_0100_0018, "R2 first read ctx 6", first_raddr, 36'h0_0100_0018);
    check(fault && fcode == 10'h004, "R4 context invalid", fcode, 10'h004);
    ctx = 8'd7;
    xlat(32'h1234_5678, 2'd0);
    check(fault && fcode == 10'h010, "R4 context page entry", fcode, 10'h010);
    ctx = 8'd5;
  endtask

  task automatic t_bypass();
    mmu_en = 1'b0; boot = 1'b1;
    xlat(32'h8765_4321, 2'd2);
    check(pa == 36'hF_F001_4321 && rights == 3'b101 && !fault, "R10 boot fetch window", pa, 36'hF_F001_4321);
    check(nreads == rd0 && nwrites == wr0, "R10 no memory access", nreads - rd0, 0);
    xlat(32'h8765_4321, 2'd0);
    check(pa == 36'h0_8765_4321 && rights == 3'b111, "R11 boot load passes through", pa, 36'h0_8765_4321);
    xlat(32'hFFFF_FFFC, 2'd1);
    check(pa == 36'h0_FFFF_FFFC && rights == 3'b111, "R11 boot store passes through", pa, 36'h0_FFFF_FFFC);
    boot = 1'b0;
    xlat(32'h0004_0010, 2'd2);
    check(pa == 36'h0_0004_0010 && rights == 3'b111 && nreads == rd0, "R11 fetch without boot", pa, 36'h0_0004_0010);
    mmu_en = 1'b1;
  endtask

  task automatic t_busy_ignore();
    int d0;
    @(negedge clk);
    d0 = ndone;
    req_valid = 1'b1; req_va = 32'h34C5_6ABC; req_kind = 2'd0;
    @(negedge clk);
    req_va = 32'h1200_0000;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    check(pa == 36'h9_ABCD_EABC, "R12 request while busy ignored", pa, 36'h9_ABCD_EABC);
    @(negedge clk);
    check(!done && !busy, "R12 done lasts one cycle", {done, busy}, 0);
    repeat (10) @(negedge clk);
    check(ndone - d0 == 1, "R12 single result", ndone - d0, 1);
  endtask

  initial begin
    mem[36'h0_0100_0014] = mk_tab(L1B);
    mem[36'h0_0100_0018] = 32'h0;
    mem[36'h0_0100_001C] = mk_pte(36'h0_1000_0000, 3'd1, 1'b1, 1'b1);
    mem[L1B + 36'h48]    = mk_pte(36'h3_4500_0000, 3'd3, 1'b1, 1'b1);
    mem[L1B + 36'hD0]    = mk_tab(L2B);
    mem[L1B + 36'h04]    = 32'h0000_0003;
    mem[L2B + 36'hAC]    = mk_pte(36'h0_8004_0000, 3'd5, 1'b0, 1'b0);
    mem[L2B + 36'hC4]    = mk_tab(L3B);
    mem[L2B + 36'h18]    = 32'h0000_0003;
    mem[L3B + 36'h58]    = mk_pte(36'h9_ABCD_E000, 3'd2, 1'b1, 1'b1);
    mem[L3B + 36'h5C]    = mk_tab(36'h0_0500_0000);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_l1_leaf();
    t_l2_leaf();
    t_l3_leaf();
    t_faults();
    t_bypass();
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule